// File: doc/BRIEF.md
# Receive Descriptor Ring Scatter Writer

This engine takes a received frame that has already passed address filtering and stores it in memory through a ring of 16-byte receive descriptors. A frame header gives the byte count, the CRC that was already computed and the broadcast and multicast class. The payload bytes then arrive one per handshake. The engine drops runts and fragments. It caps the stored length at a maximum that depends on the mode. It reads each descriptor's ownership word and its buffer pointer, then writes the frame into the buffers in chunks no larger than the programmed buffer size. The four CRC bytes follow the data, most significant byte first.

After each buffer is filled, the engine writes the descriptor's status word back and raises an event. The event is a per-buffer event for a buffer inside the frame, or a per-frame event for the last one. The descriptor pointer then steps 16 bytes, or returns to the ring base when the descriptor carries its end-of-ring mark. If a descriptor is still owned by software, the engine signals that no buffer is available and discards the rest of the frame.

All memory traffic goes through a single word-wide port with a read latency of one cycle. Data is written one byte per cycle through byte strobes.

Top module: `rxr_scatter`

## Requirements
- R1: `frame_ready` is high only while the engine is idle and both `rx_dma_en` and `rx_mac_en` are set. With either enable clear, no header is taken.
- R2: A frame with fewer than 10 bytes is always dropped. A frame with fewer than 64 bytes is dropped unless `accept_runt` is set. A dropped frame's bytes are consumed, and it causes no memory write and no event.
- R3: The stored length is the frame length plus 4. If that exceeds the maximum (1522, or 9220 with `jumbo_en`), the stored length becomes the maximum: only the first maximum-minus-4 data bytes are stored, then the CRC, and the surplus input bytes are consumed and discarded.
- R4: Each descriptor takes min(remaining stored bytes, `buf_size`) bytes. They are written starting at the buffer address read from descriptor byte offset 12. Each byte is written with a single strobe, `mem_be` = 1 << address[1:0].
- R5: The CRC follows the data, most significant byte first. When fewer than four bytes remain after a chunk, the remaining CRC bytes go into the next descriptor.
- R6: The status word at descriptor offset 0 is written back as the original word ORed with the chunk length in bits 13:0, bit 31 (ready) on every descriptor, bit 29 on the first, and on the last bit 28 plus bit 17 (broadcast), bit 16 (multicast) and bit 20 (too long).
- R7: `int_pulse` bit 0 pulses for one cycle with the last descriptor's write-back. Bit 1 pulses with the write-back of every other descriptor.
- R8: A descriptor whose status bit 31 is already set is never written. Instead `int_pulse` bit 2 pulses, the remaining frame bytes are consumed and discarded, and `desc_ptr` stays on that descriptor.
- R9: After a write-back, `desc_ptr` moves to the ring base if the fetched status word had the end-of-ring bit set (bit 15, or bit 30 when `ALT_WRAP` = 1). Otherwise it advances by 16.
- R10: A pulse on `ring_base_we` loads both the ring base and `desc_ptr` with `ring_base_din`.
- R11: After reset, `desc_ptr` is 0, `int_pulse` is 0 and no memory access is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_dma_en | input | 1 | Receive DMA enable |
| rx_mac_en | input | 1 | Receive MAC enable |
| accept_runt | input | 1 | Keep frames of 10 to 63 bytes |
| jumbo_en | input | 1 | Select the large length limit |
| buf_size | input | LEN_W | Bytes per receive buffer, nonzero |
| ring_base_we | input | 1 | Load ring base and pointer |
| ring_base_din | input | AW | New ring base address |
| frame_valid | input | 1 | Frame header offered |
| frame_ready | output | 1 | Frame header taken |
| frame_len | input | LEN_W | Frame length in bytes, CRC excluded |
| frame_crc | input | 32 | Precomputed CRC |
| frame_bcast | input | 1 | Frame is broadcast |
| frame_mcast | input | 1 | Frame is multicast |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Payload byte taken |
| in_data | input | 8 | Payload byte |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_be | output | 4 | Byte lane strobes for writes |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the read |
| int_pulse | output | 3 | Events: bit 0 frame stored, bit 1 buffer filled, bit 2 no buffer |
| desc_ptr | output | AW | Current descriptor address |

## Verification
The hardest case to reach is a frame that runs out of descriptors partway through. Bringing it about needs a small buffer size, so the frame spans several descriptors, plus a ring wrap onto a descriptor that is still marked ready. The bench sets that mark directly in its memory model before the frame. It then looks for one buffer event followed by the no-buffer event, and checks that the pointer is parked on the busy slot. A CRC split across two descriptors is forced with a buffer size two bytes larger than the frame, so the second descriptor holds only the last two CRC bytes.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH0,
    ST_FETCH3,
    ST_CHECK0,
    ST_GETBUF,
    ST_COPY,
    ST_WBACK,
    ST_DRAIN
  } rxr_state_e;

  // status word bit positions decoded by software
  localparam int RDY_BIT   = 31;
  localparam int FIRST_BIT = 29;
  localparam int LAST_BIT  = 28;
  localparam int FTL_BIT   = 20;
  localparam int BC_BIT    = 17;
  localparam int MC_BIT    = 16;
  localparam int WRAP_STD  = 15;
  localparam int WRAP_ALT  = 30;

  // event bit positions
  localparam int EV_FRAME = 0;
  localparam int EV_BUF   = 1;
  localparam int EV_NOBUF = 2;

  localparam int DESC_BYTES = 16;
  localparam int BUFPTR_OFS = 12;
  localparam int CRC_BYTES  = 4;

endpackage

// File: rtl/rxr_admit.sv
module rxr_admit #(
  parameter int LEN_W      = 14,
  parameter int CNT_W      = LEN_W + 1,
  parameter int MAX_STD    = 1522,
  parameter int MAX_JUMBO  = 9220,
  parameter int MIN_ANY    = 10,
  parameter int MIN_NORMAL = 64
) (
  input  logic [LEN_W-1:0] len,
  input  logic             accept_runt,
  input  logic             jumbo_en,
  output logic             drop,
  output logic             too_long,
  output logic [CNT_W-1:0] store_len,
  output logic [CNT_W-1:0] keep_len
);
  import rxr_pkg::*;

  logic [CNT_W-1:0] full_len;
  logic [CNT_W-1:0] limit;

  always_comb begin
    full_len  = CNT_W'(len) + CNT_W'(CRC_BYTES);
    limit     = jumbo_en ? CNT_W'(MAX_JUMBO) : CNT_W'(MAX_STD);
    too_long  = full_len > limit;
    store_len = too_long ? limit : full_len;
    keep_len  = store_len - CNT_W'(CRC_BYTES);
    drop      = (len < LEN_W'(MIN_ANY)) ||
                ((len < LEN_W'(MIN_NORMAL)) && !accept_runt);
  end

endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_we,
  input  logic [AW-1:0] load_val,
  input  logic          step_en,
  input  logic          step_wrap,
  output logic [AW-1:0] cur,
  output logic [AW-1:0] nxt
);
  import rxr_pkg::*;

  logic [AW-1:0] base_q;

  assign nxt = step_wrap ? base_q : cur + AW'(DESC_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cur    <= '0;
    end else if (load_we) begin
      base_q <= load_val;
      cur    <= load_val;
    end else if (step_en) begin
      cur <= nxt;
    end
  end

endmodule

// File: rtl/rxr_desc_fmt.sv
module rxr_desc_fmt #(
  parameter int LEN_W    = 14,
  parameter bit ALT_WRAP = 1'b0
) (
  input  logic [31:0]      orig,
  input  logic [LEN_W-1:0] chunk,
  input  logic             first,
  input  logic             last,
  input  logic             too_long,
  input  logic             bcast,
  input  logic             mcast,
  output logic [31:0]      word,
  output logic             wrap
);
  import rxr_pkg::*;

  localparam int WRAP_BIT = ALT_WRAP ? WRAP_ALT : WRAP_STD;

  logic [31:0] flags;

  always_comb begin
    flags = '0;
    flags[RDY_BIT]   = 1'b1;
    flags[FIRST_BIT] = first;
    flags[LAST_BIT]  = last;
    flags[FTL_BIT]   = last & too_long;
    flags[BC_BIT]    = last & bcast;
    flags[MC_BIT]    = last & mcast;
    word = orig | flags | 32'(chunk);
    wrap = orig[WRAP_BIT];
  end

endmodule

// File: rtl/rxr_scatter.sv
module rxr_scatter #(
  parameter int AW         = 32,
  parameter int LEN_W      = 14,
  parameter int MAX_STD    = 1522,
  parameter int MAX_JUMBO  = 9220,
  parameter int MIN_ANY    = 10,
  parameter int MIN_NORMAL = 64,
  parameter bit ALT_WRAP   = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_dma_en,
  input  logic             rx_mac_en,
  input  logic             accept_runt,
  input  logic             jumbo_en,
  input  logic [LEN_W-1:0] buf_size,
  input  logic             ring_base_we,
  input  logic [AW-1:0]    ring_base_din,
  input  logic             frame_valid,
  output logic             frame_ready,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [31:0]      frame_crc,
  input  logic             frame_bcast,
  input  logic             frame_mcast,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             mem_en,
  output logic             mem_we,
  output logic [3:0]       mem_be,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic [2:0]       int_pulse,
  output logic [AW-1:0]    desc_ptr
);
  import rxr_pkg::*;

  localparam int CNT_W = LEN_W + 1;
  localparam int LANES = 4;

  rxr_state_e       state;
  logic [LEN_W-1:0] len_r, off_r, chunk_r, drain_cnt;
  logic [CNT_W-1:0] keep_r, store_r, pos_r;
  logic [31:0]      crc_r, w0_r;
  logic [AW-1:0]    buf_r;
  logic             ftl_r, bc_r, mc_r, first_r, last_r;

  logic             adm_drop, adm_ftl;
  logic [CNT_W-1:0] adm_store, adm_keep;
  logic [AW-1:0]    ptr_cur, ptr_nxt;
  logic [31:0]      wb_word;
  logic             wrap_hit;

  logic             data_phase, byte_go;
  logic [1:0]       crc_idx;
  logic [7:0]       crc_byte, cur_byte;
  logic [31:0]      lane_word;
  logic [AW-1:0]    byte_addr;
  logic [CNT_W-1:0] rem, consumed;
  logic [LEN_W-1:0] chunk_n, lost_cnt, tail_cnt;

  rxr_admit #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .MAX_STD(MAX_STD), .MAX_JUMBO(MAX_JUMBO),
    .MIN_ANY(MIN_ANY), .MIN_NORMAL(MIN_NORMAL)
  ) u_admit (
    .len(frame_len), .accept_runt(accept_runt), .jumbo_en(jumbo_en),
    .drop(adm_drop), .too_long(adm_ftl), .store_len(adm_store), .keep_len(adm_keep)
  );

  rxr_ring_ptr #(.AW(AW)) u_ring (
    .clk(clk), .rst(rst), .load_we(ring_base_we), .load_val(ring_base_din),
    .step_en(state == ST_WBACK), .step_wrap(wrap_hit), .cur(ptr_cur), .nxt(ptr_nxt)
  );

  rxr_desc_fmt #(.LEN_W(LEN_W), .ALT_WRAP(ALT_WRAP)) u_fmt (
    .orig(w0_r), .chunk(chunk_r), .first(first_r), .last(last_r),
    .too_long(ftl_r), .bcast(bc_r), .mcast(mc_r), .word(wb_word), .wrap(wrap_hit)
  );

  assign desc_ptr    = ptr_cur;
  assign frame_ready = (state == ST_IDLE) && rx_dma_en && rx_mac_en;
  assign data_phase  = pos_r < keep_r;
  assign in_ready    = ((state == ST_COPY) && data_phase) || (state == ST_DRAIN);

  always_comb begin
    crc_idx = 2'(pos_r - keep_r);
    case (crc_idx)
      2'd0:    crc_byte = crc_r[31:24];
      2'd1:    crc_byte = crc_r[23:16];
      2'd2:    crc_byte = crc_r[15:8];
      default: crc_byte = crc_r[7:0];
    endcase
    cur_byte  = data_phase ? in_data : crc_byte;
    byte_go   = (state == ST_COPY) && (data_phase ? in_valid : 1'b1);
    byte_addr = buf_r + AW'(off_r);
    rem       = store_r - pos_r;
    chunk_n   = (rem < CNT_W'(buf_size)) ? LEN_W'(rem) : buf_size;
    consumed  = data_phase ? pos_r : keep_r;
    lost_cnt  = len_r - LEN_W'(consumed);
    tail_cnt  = len_r - LEN_W'(keep_r);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_word[8*g +: 8] = cur_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      len_r     <= '0;
      off_r     <= '0;
      chunk_r   <= '0;
      drain_cnt <= '0;
      keep_r    <= '0;
      store_r   <= '0;
      pos_r     <= '0;
      crc_r     <= '0;
      w0_r      <= '0;
      buf_r     <= '0;
      ftl_r     <= 1'b0;
      bc_r      <= 1'b0;
      mc_r      <= 1'b0;
      first_r   <= 1'b0;
      last_r    <= 1'b0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_be    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      int_pulse <= '0;
    end else begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      int_pulse <= '0;
      case (state)
        ST_IDLE: begin
          if (frame_valid && frame_ready) begin
            len_r   <= frame_len;
            keep_r  <= adm_keep;
            store_r <= adm_store;
            ftl_r   <= adm_ftl;
            bc_r    <= frame_bcast;
            mc_r    <= frame_mcast;
            crc_r   <= frame_crc;
            pos_r   <= '0;
            first_r <= 1'b1;
            if (adm_drop) begin
              drain_cnt <= frame_len;
              state     <= (frame_len == '0) ? ST_IDLE : ST_DRAIN;
            end else begin
              state <= ST_FETCH0;
            end
          end
        end
        ST_FETCH0: begin
          mem_en   <= 1'b1;
          mem_be   <= '0;
          mem_addr <= ptr_cur;
          state    <= ST_FETCH3;
        end
        ST_FETCH3: begin
          mem_en   <= 1'b1;
          mem_be   <= '0;
          mem_addr <= ptr_cur + AW'(BUFPTR_OFS);
          state    <= ST_CHECK0;
        end
        ST_CHECK0: begin
          if (mem_rdata[RDY_BIT]) begin
            int_pulse[EV_NOBUF] <= 1'b1;
            drain_cnt <= lost_cnt;
            state     <= (lost_cnt == '0) ? ST_IDLE : ST_DRAIN;
          end else begin
            w0_r  <= mem_rdata;
            state <= ST_GETBUF;
          end
        end
        ST_GETBUF: begin
          buf_r   <= mem_rdata[AW-1:0];
          chunk_r <= chunk_n;
          last_r  <= (CNT_W'(chunk_n) == rem);
          off_r   <= '0;
          state   <= ST_COPY;
        end
        ST_COPY: begin
          if (byte_go) begin
            mem_en    <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= byte_addr;
            mem_be    <= 4'b0001 << byte_addr[1:0];
            mem_wdata <= lane_word;
            pos_r     <= pos_r + 1'b1;
            off_r     <= off_r + 1'b1;
            if (off_r + 1'b1 == chunk_r) state <= ST_WBACK;
          end
        end
        ST_WBACK: begin
          mem_en    <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= ptr_cur;
          mem_be    <= 4'hF;
          mem_wdata <= wb_word;
          first_r   <= 1'b0;
          if (last_r) begin
            int_pulse[EV_FRAME] <= 1'b1;
            drain_cnt <= tail_cnt;
            state     <= (tail_cnt == '0) ? ST_IDLE : ST_DRAIN;
          end else begin
            int_pulse[EV_BUF] <= 1'b1;
            state <= ST_FETCH0;
          end
        end
        ST_DRAIN: begin
          if (in_valid) begin
            drain_cnt <= drain_cnt - 1'b1;
            if (drain_cnt == LEN_W'(1)) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxr_scatter_chk.sv
module rxr_scatter_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_dma_en,
  input logic          rx_mac_en,
  input logic          frame_ready,
  input logic          ring_base_we,
  input logic [AW-1:0] ring_base_din,
  input logic          mem_en,
  input logic          mem_we,
  input logic [3:0]    mem_be,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [2:0]    int_pulse,
  input logic [AW-1:0] desc_ptr
);

  // R1
  a_r1_ready_gated: assert property (@(posedge clk) disable iff (rst)
    frame_ready |-> (rx_dma_en && rx_mac_en));

  // R4
  a_r4_byte_lane: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1 &&
      mem_be == (4'b0001 << mem_addr[1:0])));

  // R4
  a_r4_reads_in_desc: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |-> (mem_addr[3:0] == 4'd0 || mem_addr[3:0] == 4'd12));

  // R6
  a_r6_ready_written: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we && mem_be == 4'hF) |-> (mem_wdata[31] && mem_addr[3:0] == 4'd0));

  // R7
  a_r7_single_event: assert property (@(posedge clk) disable iff (rst)
    $countones(int_pulse) <= 1);

  // R7
  a_r7_frame_event_last: assert property (@(posedge clk) disable iff (rst)
    int_pulse[0] |-> (mem_en && mem_we && mem_be == 4'hF && mem_wdata[28]));

  // R7
  a_r7_buf_event_mid: assert property (@(posedge clk) disable iff (rst)
    int_pulse[1] |-> (mem_en && mem_we && mem_be == 4'hF && !mem_wdata[28]));

  // R8
  a_r8_nobuf_no_write: assert property (@(posedge clk) disable iff (rst)
    int_pulse[2] |-> !mem_we);

  // R10
  a_r10_base_load: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ring_base_we)) |-> (desc_ptr == $past(ring_base_din)));

endmodule

bind rxr_scatter rxr_scatter_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rx_dma_en(rx_dma_en), .rx_mac_en(rx_mac_en),
  .frame_ready(frame_ready), .ring_base_we(ring_base_we), .ring_base_din(ring_base_din),
  .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .int_pulse(int_pulse), .desc_ptr(desc_ptr)
);

// File: tb/rxr_scatter_test.sv
module rxr_scatter_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LEN_W = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_dma_en = 0, rx_mac_en = 0, accept_runt = 0, jumbo_en = 0;
  logic [LEN_W-1:0] buf_size = 14'h640;
  logic ring_base_we = 0;
  logic [AW-1:0] ring_base_din = '0;
  logic frame_valid = 0;
  logic frame_ready;
  logic [LEN_W-1:0] frame_len = '0;
  logic [31:0] frame_crc = '0;
  logic frame_bcast = 0, frame_mcast = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic mem_en, mem_we;
  logic [3:0] mem_be;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [2:0] int_pulse;
  logic [AW-1:0] desc_ptr;

  logic [31:0] mem [0:4095];
  logic [69:0] exp_wr [$];
  logic [2:0]  exp_int [$];
  logic [31:0] m_ptr = '0, m_base = '0;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxr_scatter uut (.*);

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) mem[mem_addr[13:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[13:2]];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input int seed, input int p);
    return 8'((seed + p * 13) & 255);
  endfunction

  // compare every clock against the reference queues
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_en && mem_we) begin
        if (exp_wr.size() == 0) begin
          check(1'b0, "R2 unexpected memory write", mem_addr, 32'hFFFF_FFFF);
        end else begin
          logic [69:0] e;
          logic [31:0] mask;
          string tag;
          e = exp_wr.pop_front();
          mask = {{8{e[35]}}, {8{e[34]}}, {8{e[33]}}, {8{e[32]}}};
          tag = (e[69:68] == 2'd0) ? "R4 data byte" : (e[69:68] == 2'd1) ? "R5 crc byte" : "R6 writeback";
          check(mem_addr == e[67:36], $sformatf("%s address", tag), mem_addr, e[67:36]);
          check(mem_be == e[35:32], $sformatf("%s strobe", tag), 32'(mem_be), 32'(e[35:32]));
          check((mem_wdata & mask) == (e[31:0] & mask), $sformatf("%s data at %h", tag, mem_addr),
                mem_wdata & mask, e[31:0] & mask);
        end
      end
      if (int_pulse != 3'b000) begin
        if (exp_int.size() == 0) begin
          check(1'b0, "R7 unexpected event", 32'(int_pulse), 0);
        end else begin
          logic [2:0] ei;
          ei = exp_int.pop_front();
          check(int_pulse == ei, ei[2] ? "R8 no-buffer event" : "R7 event", 32'(int_pulse), 32'(ei));
        end
      end
    end
  end

  task automatic init_ring();
    for (int s = 0; s < 16; s++) begin
      mem[4*s]     = 32'h0;
      mem[4*s + 3] = 32'h1000 + 32'((s % 4) * 32'h800);
    end
    mem[4*1][30] = 1'b1;  // non-wrap bit that must survive write-back
    mem[4*3][15] = 1'b1;  // end of first ring
    mem[4*5][15] = 1'b1;  // end of second ring
  endtask

  task automatic model_frame(input int len, input logic [31:0] crc, input bit bc, input bit mc, input int seed);
    int total, keep, maxl, pos, chunk, p;
    bit ftl, first, last;
    logic [31:0] w0, nw, addr, ba, a;
    logic [7:0] b;
    logic [31:0] lw0 [16];
    if (len < 10 || (len < 64 && !accept_runt)) return;
    maxl = jumbo_en ? 9220 : 1522;
    total = len + 4;
    ftl = total > maxl;
    if (ftl) total = maxl;
    keep = total - 4;
    for (int s = 0; s < 16; s++) lw0[s] = mem[4*s];
    pos = 0; first = 1; addr = m_ptr;
    while (pos < total) begin
      w0 = lw0[addr[7:4]];
      if (w0[31]) begin
        exp_int.push_back(3'b100);
        break;
      end
      ba = mem[addr[13:2] + 3];
      chunk = (total - pos < int'(buf_size)) ? total - pos : int'(buf_size);
      for (int o = 0; o < chunk; o++) begin
        p = pos + o;
        if (p < keep) b = dbyte(seed, p);
        else b = crc[8*(3 - (p - keep)) +: 8];
        a = ba + 32'(o);
        exp_wr.push_back({(p < keep) ? 2'd0 : 2'd1, a, 4'b0001 << a[1:0], {4{b}}});
      end
      pos += chunk;
      last = (pos == total);
      nw = w0 | 32'(chunk) | 32'h8000_0000 | (first ? 32'h2000_0000 : 0);
      if (last) nw = nw | 32'h1000_0000 | (ftl ? 32'h0010_0000 : 0) |
                     (bc ? 32'h0002_0000 : 0) | (mc ? 32'h0001_0000 : 0);
      lw0[addr[7:4]] = nw;
      exp_wr.push_back({2'd2, addr, 4'hF, nw});
      exp_int.push_back(last ? 3'b001 : 3'b010);
      addr = w0[15] ? m_base : addr + 32'd16;
      first = 0;
    end
    m_ptr = addr;
  endtask

  task automatic send_frame(input int len, input logic [31:0] crc, input bit bc, input bit mc,
                            input int seed, input bit bubble, input string tag);
    bit hs;
    int i, cyc;
    model_frame(len, crc, bc, mc, seed);
    @(negedge clk);
    frame_valid = 1; frame_len = LEN_W'(len); frame_crc = crc;
    frame_bcast = bc; frame_mcast = mc;
    hs = 0;
    while (!hs) begin
      #1 hs = frame_ready;
      @(posedge clk);
      @(negedge clk);
    end
    frame_valid = 0;
    i = 0; cyc = 0;
    while (i < len) begin
      in_valid = !(bubble && (cyc % 3 == 1));
      in_data = dbyte(seed, i);
      #1 hs = in_ready && in_valid;
      @(posedge clk);
      @(negedge clk);
      if (hs) i++;
      cyc++;
    end
    in_valid = 0;
    repeat (14) @(negedge clk);
    check(exp_wr.size() == 0, $sformatf("R3 %s all writes seen", tag), 32'(exp_wr.size()), 0);
    check(exp_int.size() == 0, $sformatf("R7 %s all events seen", tag), 32'(exp_int.size()), 0);
    check(desc_ptr == m_ptr, $sformatf("R9 %s pointer", tag), desc_ptr, m_ptr);
  endtask

  task automatic load_base(input logic [31:0] v);
    @(negedge clk);
    ring_base_we = 1; ring_base_din = v;
    @(negedge clk);
    ring_base_we = 0;
    m_base = v; m_ptr = v;
    check(desc_ptr == v, "R10 base write reloads pointer", desc_ptr, v);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    init_ring();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(desc_ptr == 0, "R11 pointer after reset", desc_ptr, 0);
    check(int_pulse == 0, "R11 no event after reset", 32'(int_pulse), 0);
    check(mem_en == 0, "R11 no access after reset", 32'(mem_en), 0);
    // R1: header refused with enables off or only one set
    frame_valid = 1; frame_len = 14'd100;
    check(frame_ready == 0, "R1 ready with both enables clear", 32'(frame_ready), 0);
    rx_dma_en = 1;
    @(negedge clk);
    check(frame_ready == 0, "R1 ready with mac enable clear", 32'(frame_ready), 0);
    rx_dma_en = 0; rx_mac_en = 1;
    @(negedge clk);
    check(frame_ready == 0, "R1 ready with dma enable clear", 32'(frame_ready), 0);
    frame_valid = 0;
    rx_dma_en = 1;
    @(negedge clk);
    check(frame_ready == 1, "R1 ready with both enables set", 32'(frame_ready), 1);

    send_frame(100, 32'hA1B2C3D4, 1, 0, 5, 0, "R4 single buffer");
    send_frame(8, 32'h11111111, 0, 0, 9, 0, "R2 fragment dropped");
    send_frame(40, 32'h22222222, 0, 0, 17, 0, "R2 runt dropped");
    accept_runt = 1;
    send_frame(40, 32'h33445566, 0, 1, 21, 0, "R2 runt kept");
    accept_runt = 0;
    buf_size = 14'd66;
    send_frame(64, 32'hDEADBEEF, 0, 1, 33, 0, "R5 crc straddle");
    init_ring();
    buf_size = 14'd32;
    send_frame(100, 32'h0F1E2D3C, 1, 0, 41, 1, "R9 four buffers with wrap");
    init_ring();
    buf_size = 14'h640;
    send_frame(1530, 32'hCAFEF00D, 0, 0, 57, 0, "R3 truncated");
    init_ring();
    jumbo_en = 1;
    send_frame(1600, 32'h76543210, 0, 0, 61, 0, "R3 jumbo kept");
    jumbo_en = 0;
    init_ring();
    mem[0][31] = 1'b1;  // slot 0 still owned by software
    buf_size = 14'd32;
    send_frame(70, 32'h13579BDF, 0, 0, 71, 1, "R8 ring exhausted");
    check(desc_ptr == 32'h0, "R8 pointer parked on busy slot", desc_ptr, 32'h0);
    init_ring();
    buf_size = 14'h640;
    load_base(32'h40);
    send_frame(70, 32'h2468ACE0, 0, 0, 83, 0, "R10 second ring first slot");
    send_frame(90, 32'h89ABCDEF, 1, 0, 91, 0, "R9 second ring wrap");
    finish_run();
  end

endmodule